// File: doc/BRIEF.md
# Parking Bus Arbiter

This block decides who may use a shared external bus: a small group of on-chip masters, treated together as one side, or a single off-chip requester that signals with active-low request, grant and busy lines. A strap input, sampled while reset is held, turns the arbiter on. When it is on, the on-chip side is parked. It never runs a request/grant exchange with anyone. Whenever the bus is idle and the off-chip device does not win, the chosen on-chip master is granted on the next edge, and the arbiter pulls the busy line low on its behalf.

The off-chip device carries a programmable priority. It wins the bus when it requests and no on-chip master wants the bus. It also wins when its priority is strictly above the priority of the on-chip master that would otherwise be picked. A transfer in progress is never taken away. Arbitration runs again only at a transfer boundary, which is either the on-chip side's final-acknowledge pulse or the off-chip device releasing busy. The two off-chip inputs pass through a two-flop synchronizer before any decision uses them.

The block moves no data, so it has no valid/ready stream. Every pin is a plain control level.

Top module: `parking_bus_arbiter`

## Requirements
- R1: `arb_en_strap` is sampled on clock edges while `rst_n` is low. If it was 0, then after reset `ext_bg_n` stays 1, `int_gnt` stays 0 and `bb_oe` stays 0, whatever the requests.
- R2: With the arbiter on and the bus idle, an on-chip request that does not lose to the off-chip device is granted on the first clock edge after it appears. No handshake is involved. While that grant lasts, `bb_oe` is 1 and `bb_n_o` is 0.
- R3: Among on-chip requesters, the one with the highest priority field (`int_prio[i*PRIO_W +: PRIO_W]` for master i) is chosen. Equal fields go to the lowest index. `int_gnt` is one-hot on that index.
- R4: If the off-chip device requests (`ext_br_n` = 0) and no on-chip master requests, it is granted (`ext_bg_n` = 0), whatever `ext_prio` holds.
- R5: If both sides request, the off-chip device is granted only when `ext_prio` is strictly greater than the chosen on-chip priority. When they are equal or lower, the on-chip master is granted.
- R6: While the synchronized busy line shows the bus in use (`ext_bb_n` = 0), no new grant is issued to either side.
- R7: An on-chip grant is held unchanged until `int_done` is sampled high, even if a higher-priority off-chip request arrives meanwhile. The pending off-chip request is granted on the edge after the one that ends the on-chip grant.
- R8: When the off-chip device withdraws its request while granted and not yet busy, `ext_bg_n` returns to 1 one edge after the synchronized request falls, and the bus is parked on the on-chip side again.
- R9: When the granted off-chip device asserts busy, its grant is removed and no on-chip master is granted until busy is released.
- R10: A change on `ext_br_n` or `ext_bb_n` made before clock edge k first affects outputs after edge k+2.
- R11: `int_gnt` has at most one bit set, and it is never non-zero while `ext_bg_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| arb_en_strap | input | 1 | Arbiter enable, sampled during reset |
| ext_prio | input | PRIO_W | Priority field of the off-chip device |
| int_req | input | N_INT | On-chip master requests |
| int_prio | input | N_INT*PRIO_W | Packed on-chip priority fields |
| int_done | input | 1 | Final acknowledge of the on-chip transfer |
| int_gnt | output | N_INT | One-hot on-chip grant |
| ext_br_n | input | 1 | Off-chip bus request, active low |
| ext_bg_n | output | 1 | Off-chip bus grant, active low |
| ext_bb_n | input | 1 | Bus busy as driven by the off-chip device, active low |
| bb_n_o | output | 1 | Busy value driven for the on-chip side |
| bb_oe | output | 1 | Output enable for `bb_n_o` |

## Verification
Several properties are checked on every cycle by assertions:
- the grants never overlap and the on-chip grant stays one-hot;
- a running on-chip grant never changes before `int_done`;
- a grant never begins while the bus was seen busy;
- a withdrawn off-chip request loses its grant on the next edge;
- the picker's choice always holds the maximum priority field, with ties going to the lowest index.

Only the bench scenarios can show the end-to-end behaviour: the outcome of the priority comparison for specific settings, the exact three-edge latency through the synchronizer, the handoff to a waiting off-chip request when an on-chip transfer finishes, and the dead arbiter after a zero strap.

// File: rtl/pba_pkg.sv
package pba_pkg;
  typedef enum logic [1:0] {
    ST_PARK    = 2'd0,
    ST_INT     = 2'd1,
    ST_EXT_GNT = 2'd2,
    ST_EXT_OWN = 2'd3
  } arb_state_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pba_sync.sv
module pba_sync #(
  parameter int         W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pba_pick.sv
module pba_pick #(
  parameter int N_INT  = 3,
  parameter int PRIO_W = 3,
  localparam int IDX_W = pba_pkg::idx_width(N_INT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_INT-1:0]        req,
  input  logic [N_INT*PRIO_W-1:0] prio,
  output logic                    any,
  output logic [IDX_W-1:0]        idx,
  output logic [PRIO_W-1:0]       best
);
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N_INT; i++) begin
      if (req[i] && (!any || prio[i*PRIO_W +: PRIO_W] > best)) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        best = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

  for (genvar g = 0; g < N_INT; g++) begin : g_chk
    // R3: the chosen field is never below any requester's field
    p_pick_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req[g] |-> (any && prio[g*PRIO_W +: PRIO_W] <= best));
    // R3: ties go to the lowest index
    p_pick_tie_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req[g] && prio[g*PRIO_W +: PRIO_W] == best) |-> (idx <= IDX_W'(g)));
  end
endmodule

// File: rtl/pba_core.sv
module pba_core
  import pba_pkg::*;
#(
  parameter int N_INT  = 3,
  parameter int PRIO_W = 3,
  localparam int IDX_W = idx_width(N_INT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_on,
  input  logic              br_s,
  input  logic              bb_s,
  input  logic [PRIO_W-1:0] ext_prio,
  input  logic              pick_any,
  input  logic [IDX_W-1:0]  pick_idx,
  input  logic [PRIO_W-1:0] pick_prio,
  input  logic              int_done,
  output logic [N_INT-1:0]  int_gnt,
  output logic              ext_bg_n,
  output logic              bb_n_o,
  output logic              bb_oe
);
  arb_state_e       st_q, st_d;
  logic [IDX_W-1:0] own_q, own_d;
  logic             ext_wins;

  assign ext_wins = br_s && (!pick_any || (ext_prio > pick_prio));

  always_comb begin
    st_d  = st_q;
    own_d = own_q;
    if (!arb_on) begin
      st_d = ST_PARK;
    end else begin
      unique case (st_q)
        ST_PARK: begin
          if (!bb_s) begin
            if (ext_wins) begin
              st_d = ST_EXT_GNT;
            end else if (pick_any) begin
              st_d  = ST_INT;
              own_d = pick_idx;
            end
          end
        end
        ST_INT:     if (int_done) st_d = ST_PARK;
        ST_EXT_GNT: begin
          if (!br_s)     st_d = ST_PARK;
          else if (bb_s) st_d = ST_EXT_OWN;
        end
        ST_EXT_OWN: if (!bb_s) st_d = ST_PARK;
        default:    st_d = ST_PARK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PARK;
      own_q <= '0;
    end else begin
      st_q  <= st_d;
      own_q <= own_d;
    end
  end

  for (genvar g = 0; g < N_INT; g++) begin : g_gnt
    assign int_gnt[g] = (st_q == ST_INT) && (own_q == IDX_W'(g));
  end

  assign ext_bg_n = !(st_q == ST_EXT_GNT);
  assign bb_oe    = (st_q == ST_INT);
  assign bb_n_o   = !(st_q == ST_INT);

  // R11: exclusive grants
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_gnt) && !((int_gnt != '0) && !ext_bg_n));
  // R7: a running on-chip grant is not preempted
  p_no_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_gnt != '0) && !int_done) |=> $stable(int_gnt));
  // R8: a withdrawn request loses its grant on the next edge
  p_drop_gnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_bg_n && !br_s) |=> ext_bg_n);
  // R6: an off-chip grant starts only from an idle bus
  p_ext_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_bg_n) |-> $past(!bb_s));
  // R6: an on-chip grant starts only from an idle bus
  p_int_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_gnt != '0) && ($past(int_gnt) == '0)) |-> $past(!bb_s));
  // R2: the on-chip owner drives busy low
  p_busy_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int_gnt != '0) |-> (bb_oe && !bb_n_o));
  // R1: a disabled arbiter grants nothing
  p_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_on |=> (ext_bg_n && int_gnt == '0 && !bb_oe));
endmodule

// File: rtl/parking_bus_arbiter.sv
module parking_bus_arbiter #(
  parameter int N_INT  = 3,
  parameter int PRIO_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    arb_en_strap,
  input  logic [PRIO_W-1:0]       ext_prio,
  input  logic [N_INT-1:0]        int_req,
  input  logic [N_INT*PRIO_W-1:0] int_prio,
  input  logic                    int_done,
  output logic [N_INT-1:0]        int_gnt,
  input  logic                    ext_br_n,
  output logic                    ext_bg_n,
  input  logic                    ext_bb_n,
  output logic                    bb_n_o,
  output logic                    bb_oe
);
  localparam int IDX_W = pba_pkg::idx_width(N_INT);

  logic              en_q;
  logic [1:0]        ext_sync;
  logic              br_s, bb_s;
  logic              pick_any;
  logic [IDX_W-1:0]  pick_idx;
  logic [PRIO_W-1:0] pick_prio;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= arb_en_strap;
  end

  pba_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ext_br_n, ext_bb_n}),
    .q     (ext_sync)
  );

  assign br_s = !ext_sync[1];
  assign bb_s = !ext_sync[0];

  pba_pick #(.N_INT(N_INT), .PRIO_W(PRIO_W)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (int_req),
    .prio  (int_prio),
    .any   (pick_any),
    .idx   (pick_idx),
    .best  (pick_prio)
  );

  pba_core #(.N_INT(N_INT), .PRIO_W(PRIO_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .arb_on    (en_q),
    .br_s      (br_s),
    .bb_s      (bb_s),
    .ext_prio  (ext_prio),
    .pick_any  (pick_any),
    .pick_idx  (pick_idx),
    .pick_prio (pick_prio),
    .int_done  (int_done),
    .int_gnt   (int_gnt),
    .ext_bg_n  (ext_bg_n),
    .bb_n_o    (bb_n_o),
    .bb_oe     (bb_oe)
  );
endmodule

// File: tb/parking_bus_arbiter_bench.sv
module parking_bus_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  typedef struct packed {
    logic [2:0] ep;
    logic [2:0] rq;
    logic [8:0] pr;
    logic       br;
    logic       xe;
    logic [2:0] xi;
  } vec_t;

  // ext_prio, int_req, {p2,p1,p0}, ext requests, expect ext grant, expect int grant
  localparam vec_t VEC [NV] = '{
    '{3'd5, 3'b000, {3'd0,3'd0,3'd0}, 1'b1, 1'b1, 3'b000},
    '{3'd0, 3'b000, {3'd0,3'd0,3'd0}, 1'b1, 1'b1, 3'b000},
    '{3'd2, 3'b001, {3'd0,3'd0,3'd4}, 1'b1, 1'b0, 3'b001},
    '{3'd6, 3'b011, {3'd0,3'd5,3'd4}, 1'b1, 1'b1, 3'b000},
    '{3'd5, 3'b011, {3'd0,3'd5,3'd4}, 1'b1, 1'b0, 3'b010},
    '{3'd0, 3'b111, {3'd1,3'd3,3'd3}, 1'b0, 1'b0, 3'b001},
    '{3'd7, 3'b100, {3'd7,3'd0,3'd0}, 1'b1, 1'b0, 3'b100},
    '{3'd0, 3'b110, {3'd6,3'd2,3'd0}, 1'b0, 1'b0, 3'b100},
    '{3'd3, 3'b101, {3'd2,3'd0,3'd1}, 1'b1, 1'b1, 3'b000}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arb_en_strap = 1'b1;
  logic [2:0] ext_prio = '0;
  logic [2:0] int_req = '0;
  logic [8:0] int_prio = '0;
  logic       int_done = 1'b0;
  logic [2:0] int_gnt;
  logic       ext_br_n = 1'b1;
  logic       ext_bg_n;
  logic       ext_bb_n = 1'b1;
  logic       bb_n_o;
  logic       bb_oe;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  parking_bus_arbiter u_parking_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .arb_en_strap(arb_en_strap),
    .ext_prio(ext_prio), .int_req(int_req), .int_prio(int_prio),
    .int_done(int_done), .int_gnt(int_gnt), .ext_br_n(ext_br_n),
    .ext_bg_n(ext_bg_n), .ext_bb_n(ext_bb_n), .bb_n_o(bb_n_o), .bb_oe(bb_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; arb_en_strap = strap;
    int_req = '0; ext_br_n = 1'b1; ext_bb_n = 1'b1; int_done = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: strap 0 leaves the arbiter dead
    do_reset(1'b0);
    int_req = 3'b111; int_prio = 9'o777; ext_br_n = 1'b0; ext_prio = 3'd7;
    tick(6);
    chk("R1 disabled ext grant", {7'd0, ext_bg_n}, 8'd1);
    chk("R1 disabled int grant", {5'd0, int_gnt}, 8'd0);
    chk("R1 disabled busy enable", {7'd0, bb_oe}, 8'd0);

    do_reset(1'b1);
    chk("R1 reset outputs", {4'd0, ext_bg_n, int_gnt}, 8'h08);

    // Table walk: R3, R4, R5, R6
    for (int v = 0; v < NV; v++) begin
      ext_bb_n = 1'b0;
      tick(3);
      ext_prio = VEC[v].ep; int_req = VEC[v].rq; int_prio = VEC[v].pr;
      ext_br_n = !VEC[v].br;
      tick(3);
      chk("R6 no grant while busy", {4'd0, ext_bg_n, int_gnt}, 8'h08);
      ext_bb_n = 1'b1;
      tick(4);
      chk("R4/R5 ext grant", {7'd0, !ext_bg_n}, {7'd0, VEC[v].xe});
      chk("R3/R5 int grant", {5'd0, int_gnt}, {5'd0, VEC[v].xi});
      ext_br_n = 1'b1; int_req = '0;
      if (int_gnt != '0) begin
        int_done = 1'b1; tick(1); int_done = 1'b0;
      end
      tick(4);
    end

    // R2: parked seize on the first edge
    int_prio = 9'o000; int_req = 3'b010;
    tick(1);
    chk("R2 parked grant", {5'd0, int_gnt}, 8'h02);
    chk("R2 busy driven", {6'd0, bb_oe, bb_n_o}, 8'h02);

    // R7: no preemption, then handoff
    ext_prio = 3'd7; ext_br_n = 1'b0;
    tick(5);
    chk("R7 held grant", {4'd0, ext_bg_n, int_gnt}, 8'h0A);
    int_req = '0; int_done = 1'b1; tick(1); int_done = 1'b0;
    chk("R7 end of transfer", {3'd0, ext_bg_n, bb_oe, int_gnt}, 8'h10);
    tick(1);
    chk("R7 handoff to off-chip", {7'd0, ext_bg_n}, 8'd0);

    // R9: off-chip takes the bus
    ext_bb_n = 1'b0; int_req = 3'b001;
    tick(2);
    chk("R10 grant kept two edges", {7'd0, ext_bg_n}, 8'd0);
    tick(1);
    chk("R9 grant removed when busy", {4'd0, ext_bg_n, int_gnt}, 8'h08);
    tick(3);
    chk("R9 no int grant while busy", {5'd0, int_gnt}, 8'd0);
    ext_br_n = 1'b1; ext_bb_n = 1'b1;
    tick(3);
    chk("R10 busy release latency", {5'd0, int_gnt}, 8'd0);
    tick(1);
    chk("R9 int grant after release", {5'd0, int_gnt}, 8'h01);
    int_req = '0; int_done = 1'b1; tick(1); int_done = 1'b0;
    tick(2);

    // R8/R10: request latency and withdrawal
    ext_br_n = 1'b0;
    tick(2);
    chk("R10 request not yet seen", {7'd0, ext_bg_n}, 8'd1);
    tick(1);
    chk("R10 grant after three edges", {7'd0, ext_bg_n}, 8'd0);
    ext_br_n = 1'b1;
    tick(2);
    chk("R8 grant before sync", {7'd0, ext_bg_n}, 8'd0);
    tick(1);
    chk("R8 grant removed", {7'd0, ext_bg_n}, 8'd1);
    int_req = 3'b100;
    tick(1);
    chk("R8 parking returned", {5'd0, int_gnt}, 8'h04);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule